// File: doc/BRIEF.md
# Doorbell Pending Register with Zero-Write Acknowledge

The block keeps one 32-bit word of pending doorbells. Another agent raises doorbells through a set port by presenting a mask with any number of bits set. A processor reads the word through a simple strobe port. It acknowledges what it has handled by writing the bitwise inverse of the value it read. A zero in the written data clears the bit at that position. A one in the written data leaves that bit as it is. Because of this, a doorbell that arrives between the read and the acknowledge survives the acknowledge.

The word is split into two fixed, disjoint groups, each selected by a constant mask parameter. The processor-to-processor group drives interrupt line 0. The message group drives interrupt line 1. Each line is the registered OR of the pending bits in its group.

Top module: `dbell_cause`

## Requirements
- R1: A synchronous active-high reset clears every pending bit and drives both interrupt outputs low.
- R2: A set-port mask with bit i high makes pending bit i high from the next clock edge, whatever the value of the other bits.
- R3: During a write strobe, a 0 in bit i of the write data clears pending bit i at the next edge.
- R4: During a write strobe, a 1 in bit i of the write data leaves pending bit i unchanged.
- R5: When the set mask and a zero-write hit the same bit in the same cycle, the bit ends up pending.
- R6: A read returns the pending word combinationally, in the same cycle as the read strobe. While the read strobe is low, the read data is zero.
- R7: Interrupt line 0 is high one cycle after any pending bit inside the processor-to-processor group mask (default 0x0000FFFF) is high, and low otherwise.
- R8: Interrupt line 1 is high one cycle after any pending bit inside the message group mask (default 0xFFFF0000) is high, and low otherwise.
- R9: Suppose a doorbell is raised after a read and before the acknowledge that writes the inverse of the value read. That doorbell stays pending after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_mask | input | 32 | Doorbells to raise this cycle |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write (acknowledge) strobe |
| cpu_wdata | input | 32 | Acknowledge data, zero bits clear |
| cpu_rdata | output | 32 | Pending word while reading |
| irq_ipi | output | 1 | Processor-to-processor group interrupt |
| irq_msg | output | 1 | Message group interrupt |

## Verification
Pending bits change one edge after a raise or an acknowledge. The interrupt lines follow one edge after that, so they are due two edges after the stimulus. Read data is valid in the same cycle as the strobe. A behavioural model in the bench keeps a pending word and a one-deep delayed copy for the interrupts, and advances on every edge. The bench compares it with the outputs at the falling edge, with the read strobe held high, so every result is sampled at its due cycle. The race case is driven directly: read, raise a new bit, then write the inverse of the value read.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
    localparam int unsigned DB_W = 32;
    typedef logic [DB_W-1:0] db_word_t;

    typedef struct packed {
        logic     wr;
        db_word_t data;
    } ack_req_t;

    function automatic db_word_t next_pending(db_word_t cur, db_word_t raise, ack_req_t ack);
        db_word_t kept;
        kept = ack.wr ? (cur & ack.data) : cur;
        return kept | raise;
    endfunction
endpackage

// File: rtl/dbell_store.sv
module dbell_store
    import dbell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  db_word_t raise_mask,
    input  ack_req_t ack,
    output db_word_t pending
);
    db_word_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= next_pending(pend_q, raise_mask, ack);
    end

    assign pending = pend_q;

    // R2
    raise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (raise_mask != '0) |=> ((pend_q & $past(raise_mask)) == $past(raise_mask)));
    // R4
    one_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        ack.wr |=> ((pend_q & $past(pend_q) & $past(ack.data)) == ($past(pend_q) & $past(ack.data))));
    // R3
    zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ack.wr |=> ((pend_q & ~$past(ack.data) & ~$past(raise_mask)) == '0));
endmodule

// File: rtl/dbell_irq.sv
module dbell_irq
    import dbell_pkg::*;
#(
    parameter db_word_t GRP_MASK = 32'h0000FFFF
)(
    input  logic     clk,
    input  logic     rst,
    input  db_word_t pending,
    output logic     irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pending & GRP_MASK);
    end

    assign irq = irq_q;

    // R7 R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_q == |($past(pending) & GRP_MASK)));
endmodule

// File: rtl/dbell_cause.sv
module dbell_cause
    import dbell_pkg::*;
#(
    parameter logic [31:0] IPI_MASK = 32'h0000FFFF,
    parameter logic [31:0] MSG_MASK = 32'hFFFF0000
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] raise_mask,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        irq_ipi,
    output logic        irq_msg
);
    localparam int unsigned NGRP = 2;
    localparam logic [NGRP*DB_W-1:0] GMASKS = {MSG_MASK, IPI_MASK};

    db_word_t   pending;
    ack_req_t   ack;
    logic [NGRP-1:0] irq_v;

    assign ack = '{wr: cpu_wr, data: cpu_wdata};

    dbell_store u_store (
        .clk(clk), .rst(rst), .raise_mask(raise_mask), .ack(ack), .pending(pending)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        dbell_irq #(.GRP_MASK(GMASKS[g*DB_W +: DB_W])) u_irq (
            .clk(clk), .rst(rst), .pending(pending), .irq(irq_v[g])
        );
    end

    assign irq_ipi   = irq_v[0];
    assign irq_msg   = irq_v[1];
    assign cpu_rdata = cpu_rd ? pending : '0;

    initial begin
        // masks must be disjoint
        assert ((IPI_MASK & MSG_MASK) == '0);
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && ((raise_mask & ~cpu_wdata) != '0)) |=>
        ((pending & $past(raise_mask & ~cpu_wdata)) == $past(raise_mask & ~cpu_wdata)));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pending == '0 && !irq_ipi && !irq_msg));
endmodule

// File: tb/dbell_cause_test.sv
module dbell_cause_test;
    logic        clk = 0;
    logic        rst;
    logic [31:0] raise_mask;
    logic        cpu_rd, cpu_wr;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic        irq_ipi, irq_msg;

    int checks = 0, fails = 0;
    bit done = 0;

    // model
    logic [31:0] m_pend;
    logic        m_ipi, m_msg;
    localparam logic [31:0] IPI_M = 32'h0000FFFF;
    localparam logic [31:0] MSG_M = 32'hFFFF0000;

    always #4 clk = ~clk;

    dbell_cause uut (.*);

    always @(posedge clk) begin
        if (rst) begin
            m_pend <= 0; m_ipi <= 0; m_msg <= 0;
        end else begin
            m_ipi  <= (m_pend & IPI_M) != 0;
            m_msg  <= (m_pend & MSG_M) != 0;
            m_pend <= (cpu_wr ? (m_pend & cpu_wdata) : m_pend) | raise_mask;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-cycle comparison at falling edge (R6 R7 R8)
    always @(negedge clk) if (!rst && !done) begin
        chk("R6", cpu_rdata, cpu_rd ? m_pend : 32'h0);
        chk("R7", {31'b0, irq_ipi}, {31'b0, m_ipi});
        chk("R8", {31'b0, irq_msg}, {31'b0, m_msg});
    end

    task automatic step(logic [31:0] r, logic w, logic [31:0] d);
        raise_mask = r; cpu_wr = w; cpu_wdata = d;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seen;
        rst = 1; raise_mask = 0; cpu_rd = 1; cpu_wr = 0; cpu_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1", cpu_rdata, 0);
        chk("R1", {30'b0, irq_ipi, irq_msg}, 0);
        // R2: raise in each group
        step(32'h0000_0004, 0, 0);
        step(0, 0, 0);
        chk("R2", cpu_rdata, 32'h4);
        step(0, 0, 0);
        chk("R7", {31'b0, irq_ipi}, 1);
        chk("R8", {31'b0, irq_msg}, 0);
        step(32'h8001_0000, 0, 0);
        step(0, 0, 0);
        chk("R8", {31'b0, irq_msg}, 1);
        // R3/R4: clear bit 2 only
        step(0, 1, ~32'h4);
        chk("R3", cpu_rdata, 32'h8001_0000);
        chk("R4", cpu_rdata & 32'h8001_0000, 32'h8001_0000);
        step(0, 0, 0);
        chk("R7", {31'b0, irq_ipi}, 0);
        // R4: all-ones write no effect
        step(0, 1, 32'hFFFF_FFFF);
        chk("R4", cpu_rdata, 32'h8001_0000);
        // R5: set and clear same bit
        step(32'h0001_0000, 1, ~32'h0001_0000);
        chk("R5", cpu_rdata, 32'h8001_0000);
        // R6: read strobe low gives zero
        cpu_rd = 0; step(0, 0, 0);
        chk("R6", cpu_rdata, 0);
        cpu_rd = 1; step(0, 0, 0);
        // R9: race
        step(32'h0000_0300, 0, 0);
        seen = cpu_rdata;
        step(32'h0000_0020, 0, 0);
        step(0, 1, ~seen);
        chk("R9", cpu_rdata, 32'h0000_0020);
        step(0, 0, 0);
        chk("R7", {31'b0, irq_ipi}, 1);
        chk("R8", {31'b0, irq_msg}, 0);
        // random traffic
        for (int i = 0; i < 200; i++) begin
            cpu_rd = ($urandom % 4) != 0;
            step($urandom & $urandom & $urandom, ($urandom % 2) == 1, $urandom | $urandom);
        end
        cpu_rd = 1;
        // R1: reset mid-run
        rst = 1; step(0, 0, 0); rst = 0;
        chk("R1", cpu_rdata, 0);
        chk("R1", {30'b0, irq_ipi, irq_msg}, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule